// File: doc/BRIEF.md
# Timing Reference Word Framer

This block sits behind a deserializer that delivers 10-bit characters with no knowledge of where the true word boundaries fall. It keeps the last four received characters as a 40-bit bit-serial window. Bit 0 of each character is the earliest bit in time. Each cycle it tests every one of the ten possible bit offsets for the 30-bit timing reference: a word of all ones followed by two words of all zeros.

The offset at which that reference was last accepted is held in a register. Every outgoing character is cut out of two adjacent input characters by a barrel shifter that uses the held offset. When the reference turns up at some other offset, the block raises an error flag for one cycle. It moves to the new offset only if the sync-enable input is high. A one-cycle horizontal sync pulse marks the first character that follows a reference found on the boundary now in force. Input characters may arrive with gaps. Each one produces exactly one output character.

Top module: `trs_framer`

## Requirements
- R1: The reference is the bit sequence of ten ones followed by twenty zeros, with bit 0 of each character earliest. It is recognised at every bit offset 0 to 9 relative to the input character boundaries.
- R2: Each output character is the ten consecutive stream bits starting at the held offset. When the offset equals the reference position, the character following the reference comes out unchanged.
- R3: A reference found at an offset other than the held one, with sync-enable high in the detection cycle, loads that offset. The offset applies from the next output character onward and stays within 0 to 9.
- R4: With sync-enable low, the held offset never changes. A reference at another offset does not realign the output.
- R5: Sync error is high for exactly one cycle, together with the output character that carries the third reference word, when the reference is found at an offset different from the held one. It stays low for a reference at the held offset.
- R6: Horizontal sync is high for one cycle with the output character immediately after the third reference word. This happens only when the reference position equals the offset in force after the update. Otherwise sync stays low.
- R7: Output valid follows each input valid by exactly two clock cycles, one output per input, including when input characters arrive with idle cycles between them.
- R8: Reset sets the held offset to 0 and clears output valid, output data, sync error and horizontal sync.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Character clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_data | input | 10 | Unaligned received character, bit 0 earliest |
| in_valid | input | 1 | in_data carries a character this cycle |
| sync_en | input | 1 | Permits loading a new word offset |
| out_data | output | 10 | Realigned character |
| out_valid | output | 1 | out_data carries a character this cycle |
| hsync | output | 1 | Marks the character after a framed reference |
| sync_err | output | 1 | Reference found off the held boundary |

## Verification
Streams are built bit by bit with the reference placed at offsets 0, 3, 5, 7 and 9. Two known payload characters follow each reference. Recovering both payloads intact shows that the search and the barrel shifter agree on each offset. A reference at the held offset with sync-enable low separates a match, which gives sync and no error, from a mismatch. A mismatch with sync-enable low, followed by a reference at the old offset, shows that the offset was held rather than loaded. Streams with idle cycles between characters separate correct valid tracking from tracking tied to the clock alone. A reset in mid-stream followed by an offset-0 reference shows that the offset returns to zero.

// File: rtl/trs_pkg.sv
package trs_pkg;
  // Reference pattern as it sits in a bit-serial window: the first word
  // (all ones) occupies the lowest bits, the trailing zero words above it.
  function automatic logic [63:0] ref_pattern(input int w, input int nword);
    logic [63:0] p;
    p = '0;
    for (int i = 0; i < w; i++) p[i] = 1'b1;
    return p;
  endfunction
endpackage

// File: rtl/trs_history.sv
module trs_history #(
  parameter int W     = 10,
  parameter int DEPTH = 4,
  localparam int WIN  = W * DEPTH
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           shift_en,
  input  logic [W-1:0]   din,
  output logic [WIN-1:0] win
);
  logic [W-1:0] stage_q [DEPTH];
  logic [W-1:0] stage_d [DEPTH];

  always_comb begin
    for (int k = 0; k < DEPTH; k++) stage_d[k] = stage_q[k];
    if (shift_en) begin
      stage_d[0] = din;
      for (int k = 1; k < DEPTH; k++) stage_d[k] = stage_q[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= '0;
    end else begin
      for (int k = 0; k < DEPTH; k++) stage_q[k] <= stage_d[k];
    end
  end

  // newest stage in the top bits, oldest at bit 0
  for (genvar k = 0; k < DEPTH; k++) begin : g_pack
    assign win[W*(DEPTH-1-k) +: W] = stage_q[k];
  end
endmodule

// File: rtl/trs_search.sv
module trs_search #(
  parameter int W     = 10,
  parameter int NWORD = 3,
  localparam int WIN  = W * (NWORD + 1),
  localparam int PLEN = W * NWORD,
  localparam int OW   = $clog2(W)
) (
  input  logic [WIN-1:0] win,
  output logic           found,
  output logic [OW-1:0]  found_off
);
  import trs_pkg::*;
  localparam logic [63:0] PAT64 = ref_pattern(W, NWORD);
  localparam logic [PLEN-1:0] PAT = PAT64[PLEN-1:0];

  logic [W-1:0] match;

  for (genvar o = 0; o < W; o++) begin : g_off
    assign match[o] = (win[o +: PLEN] == PAT);
  end

  always_comb begin
    found     = |match;
    found_off = '0;
    for (int o = W - 1; o >= 0; o--) begin
      if (match[o]) found_off = OW'(o);
    end
  end
endmodule

// File: rtl/trs_align.sv
module trs_align #(
  parameter int W  = 10,
  localparam int OW = $clog2(W)
) (
  input  logic [2*W-1:0] pair,
  input  logic [OW-1:0]  sel,
  output logic [W-1:0]   word
);
  logic [W-1:0] cand [W];

  for (genvar o = 0; o < W; o++) begin : g_tap
    assign cand[o] = pair[o +: W];
  end

  always_comb begin
    word = cand[0];
    for (int o = 1; o < W; o++) begin
      if (sel == OW'(o)) word = cand[o];
    end
  end
endmodule

// File: rtl/trs_framer.sv
module trs_framer #(
  parameter int W     = 10,
  parameter int NWORD = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] in_data,
  input  logic         in_valid,
  input  logic         sync_en,
  output logic [W-1:0] out_data,
  output logic         out_valid,
  output logic         hsync,
  output logic         sync_err
);
  localparam int DEPTH = NWORD + 1;
  localparam int WIN   = W * DEPTH;
  localparam int OW    = $clog2(W);

  // reset: asserted asynchronously, released on a clock edge
  logic [1:0] rsync_q;
  logic       rst_int_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  logic [WIN-1:0] win;
  logic           found;
  logic [OW-1:0]  found_off;
  logic [W-1:0]   aligned;

  logic           vld_q;
  logic [OW-1:0]  off_q, off_d;
  logic           pend_q, pend_d;
  logic [W-1:0]   data_q, data_d;
  logic           oval_q, oval_d;
  logic           hs_q, hs_d;
  logic           err_q, err_d;
  logic           hit, mism, good;

  trs_history #(.W(W), .DEPTH(DEPTH)) u_hist (
    .clk(clk), .rst_n(rst_int_n), .shift_en(in_valid), .din(in_data), .win(win)
  );

  trs_search #(.W(W), .NWORD(NWORD)) u_search (
    .win(win), .found(found), .found_off(found_off)
  );

  trs_align #(.W(W)) u_align (
    .pair(win[WIN-1 -: 2*W]), .sel(off_q), .word(aligned)
  );

  always_comb begin
    hit    = vld_q & found;
    mism   = hit & (found_off != off_q);
    good   = hit & (~mism | sync_en);
    off_d  = (mism & sync_en) ? found_off : off_q;
    pend_d = vld_q ? good : pend_q;
    hs_d   = vld_q & pend_q;
    err_d  = mism;
    oval_d = vld_q;
    data_d = vld_q ? aligned : data_q;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      vld_q  <= 1'b0;
      off_q  <= '0;
      pend_q <= 1'b0;
      data_q <= '0;
      oval_q <= 1'b0;
      hs_q   <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      vld_q  <= in_valid;
      off_q  <= off_d;
      pend_q <= pend_d;
      data_q <= data_d;
      oval_q <= oval_d;
      hs_q   <= hs_d;
      err_q  <= err_d;
    end
  end

  assign out_data  = data_q;
  assign out_valid = oval_q;
  assign hsync     = hs_q;
  assign sync_err  = err_q;
endmodule

// File: rtl/trs_framer_chk.sv
module trs_framer_chk #(
  parameter int W  = 10,
  parameter int OW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          sync_en,
  input logic          out_valid,
  input logic          hsync,
  input logic          sync_err,
  input logic [OW-1:0] off_q
);
  AST_ERR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |=> !sync_err); // R5
  AST_ERR_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    sync_err |-> out_valid); // R5
  AST_HSYNC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |=> !hsync); // R6
  AST_HSYNC_WITH_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    hsync |-> out_valid); // R6
  AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (off_q != $past(off_q)) |-> $past(sync_en)); // R4
  AST_OFF_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    off_q <= OW'(W - 1)); // R3
  AST_VALID_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(in_valid, 2)); // R7
endmodule

bind trs_framer trs_framer_chk #(.W(W), .OW(OW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .sync_en(sync_en),
  .out_valid(out_valid), .hsync(hsync), .sync_err(sync_err), .off_q(off_q)
);

// File: tb/sim_trs_framer.sv
module sim_trs_framer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] in_data = '0;
  logic       in_valid = 1'b0;
  logic       sync_en = 1'b0;
  logic [9:0] out_data;
  logic       out_valid, hsync, sync_err;

  int errors = 0, checks = 0;
  int nval, nhs, nerr, nerr_nv, cycles = 0;
  logic [9:0] cap1, cap2;
  logic want2;

  always #5 clk = ~clk;

  trs_framer u0 (
    .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
    .sync_en(sync_en), .out_data(out_data), .out_valid(out_valid),
    .hsync(hsync), .sync_err(sync_err)
  );

  // {shift[3:0], sync_en, gap, expect_err, expect_hsync}
  localparam int NCASE = 9;
  localparam logic [7:0] CASES [NCASE] = '{
    {4'd0, 1'b0, 1'b0, 1'b0, 1'b1},  // offset 0 from reset
    {4'd3, 1'b1, 1'b0, 1'b1, 1'b1},  // load 3
    {4'd3, 1'b1, 1'b1, 1'b0, 1'b1},  // match, with gaps
    {4'd7, 1'b0, 1'b0, 1'b1, 1'b0},  // mismatch, held
    {4'd3, 1'b0, 1'b0, 1'b0, 1'b1},  // held offset still 3
    {4'd9, 1'b1, 1'b1, 1'b1, 1'b1},  // load 9, gaps
    {4'd0, 1'b1, 1'b0, 1'b1, 1'b1},  // load 0
    {4'd0, 1'b0, 1'b1, 1'b0, 1'b1},  // match 0, gaps
    {4'd5, 1'b1, 1'b0, 1'b1, 1'b1}   // load 5
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cycles++;
    if (rst_n) begin
      if (out_valid) begin
        nval++;
        if (want2) begin cap2 = out_data; want2 = 1'b0; end
        if (hsync) begin nhs++; cap1 = out_data; want2 = 1'b1; end
      end
      if (sync_err) begin
        nerr++;
        if (!out_valid) nerr_nv++;
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic run_case(input int shift, input logic sen, input logic gap,
                          input logic exp_err, input logic exp_hs, input int id);
    logic [99:0] bits;
    logic [9:0] p1, p2;
    int s;
    p1 = 10'(10'h1C3 + id * 7);
    p2 = 10'(10'h24E - id * 11);
    for (int b = 0; b < 100; b++) bits[b] = (b % 2 == 0);
    s = 20 + shift;
    for (int k = 0; k < 30; k++) bits[s + k] = (k < 10);
    for (int k = 0; k < 10; k++) begin
      bits[s + 30 + k] = p1[k];
      bits[s + 40 + k] = p2[k];
    end
    nval = 0; nhs = 0; nerr = 0; nerr_nv = 0; want2 = 1'b0;
    cap1 = '0; cap2 = '0;
    sync_en = sen;
    for (int w = 0; w < 10; w++) begin
      in_data = bits[10*w +: 10];
      in_valid = 1'b1;
      tick();
      if (gap) begin in_valid = 1'b0; tick(); end
    end
    in_valid = 1'b0;
    repeat (4) tick();
    chk(nval == 10, $sformatf("R7 case %0d valid count", id), nval, 10);
    chk(nerr == int'(exp_err), $sformatf("R5 case %0d sync_err count", id), nerr, exp_err);
    chk(nerr_nv == 0, $sformatf("R5 case %0d err without valid", id), nerr_nv, 0);
    chk(nhs == int'(exp_hs), $sformatf("R6 case %0d hsync count (R1 R4)", id), nhs, exp_hs);
    if (exp_hs) begin
      chk(cap1 == p1, $sformatf("R2 case %0d first payload (R3)", id), cap1, p1);
      chk(cap2 == p2, $sformatf("R2 case %0d second payload", id), cap2, p2);
    end
  endtask

  initial begin
    repeat (3) tick();
    chk(out_valid == 1'b0 && hsync == 1'b0 && sync_err == 1'b0 && out_data == '0,
        "R8 outputs in reset", {out_valid, hsync, sync_err}, 0);
    rst_n = 1'b1;
    repeat (4) tick();
    for (int i = 0; i < NCASE; i++) begin
      run_case(int'(CASES[i][7:4]), CASES[i][3], CASES[i][2], CASES[i][1], CASES[i][0], i);
    end
    // reset in mid-run: offset returns to 0
    rst_n = 1'b0;
    #2;
    chk(out_valid == 1'b0 && hsync == 1'b0 && sync_err == 1'b0 && out_data == '0,
        "R8 outputs after mid-run reset", {out_valid, hsync, sync_err}, 0);
    repeat (2) tick();
    rst_n = 1'b1;
    repeat (4) tick();
    run_case(0, 1'b0, 1'b0, 1'b0, 1'b1, 20);  // R8 offset back to zero
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    wait (cycles > 20000);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 20000);
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule